// File: doc/BRIEF.md
# Boot-Area Command Interpreter

This block sits behind the boot-buffer window of a flash device and interprets the 16-bit host writes that land there. It offers three things. A single write can trigger a warm reset. Another single write produces an identification record for the buffer. A two-write sequence starts a full-page load: an arm code, then a zero confirm.

When a confirmed load is issued, the block raises a page-load request that carries the target sector. The sector is formed from an external block-address value and an internal page-address register. After the request is issued, the page register steps to the next page. A data mover downstream accepts the request over a valid/ready handshake, and only one request can be outstanding at a time. The host can also load the page register directly.

Top module: `boot_cmd_ctrl`

## Requirements
- R1: Only write strobes whose word address lies in 0x0000–0x01FF or 0x8000–0x800F are interpreted. Any other write changes nothing: the armed flag keeps its value and no pulse or request is produced.
- R2: In the idle (not armed) state, a window write of 0x00F0 gives a one-cycle `warm_rst_o` pulse in the next cycle and clears the page register to 0.
- R3: In the idle state, a window write of 0x0090 gives a one-cycle `id_wr_o` pulse in the next cycle. `id_data_o` then holds three words with the upper byte of each cleared: bits 15:0 carry the low byte of `man_id_i`, bits 31:16 the low byte of `dev_id_i`, and bits 47:32 the low byte of `wp_stat_i`.
- R4: In the idle state, a window write of 0x00E0 sets `armed_o` in the next cycle. While armed, the next window write of any value clears `armed_o`, and that write is not interpreted as a single-write command.
- R5: An armed window write of 0x0000, made while the request port is free, raises `ld_valid_o` in the next cycle. In the same cycle the page register becomes ((page[7:0] + 4) mod 256), with bits 15:8 cleared.
- R6: The request sector equals ((F·64 + page[7:2])·4 + page[1:0]). Here F is `blk_addr_i[11:0]`, ORed with the DENSITY_MASK parameter when `blk_addr_i[15]` is 1.
- R7: Once raised, `ld_valid_o` and `ld_sector_o` hold until a cycle with `ld_ready_i` high. A confirm made in that same cycle is taken as a new request. A confirm made while the port is occupied and not ready is dropped: no new request is made and the page register is unchanged, but the armed state is still consumed.
- R8: In the idle state, a window write of any value other than 0x00F0, 0x00E0 or 0x0090 is ignored. It produces no pulse, no request and no arming.
- R9: A `pg_wr_i` strobe loads `pg_wdata_i` into the page register. It takes priority over a step or a clear in the same cycle.
- R10: While `rst_ni` is low, `armed_o`, `ld_valid_o`, `warm_rst_o` and `id_wr_o` are 0, and `page_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 16 | Host word address |
| wr_data_i | input | 16 | Host write data |
| blk_addr_i | input | 16 | Block-address register value |
| pg_wr_i | input | 1 | Host load of the page register |
| pg_wdata_i | input | 16 | Page register load value |
| man_id_i | input | 16 | Manufacturer identifier |
| dev_id_i | input | 16 | Device identifier |
| wp_stat_i | input | 16 | Write-protect status |
| ld_ready_i | input | 1 | Downstream accepts the load request |
| ld_valid_o | output | 1 | Load request pending |
| ld_sector_o | output | BLK_W+8 | Target sector of the request |
| page_o | output | 16 | Page register |
| armed_o | output | 1 | Load sequence armed |
| warm_rst_o | output | 1 | Warm reset pulse |
| id_wr_o | output | 1 | Identification record write pulse |
| id_data_o | output | 48 | Identification record, three words |

## Verification
Two events can fall in the same cycle: the downstream acceptance of a pending request, and a new zero confirm. There is a second collision between a host load of the page register and the step that a confirm causes. The stimulus draws `ld_ready_i` and `pg_wr_i` at random during armed confirms, and it also forces each collision in a directed step. The outputs are compared every cycle against a bench model. That model must show back-to-back requests when acceptance and confirm coincide, a dropped confirm when the port is occupied and not ready, and the host value winning over the step.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;
  localparam logic [15:0] CODE_WRST = 16'h00F0;
  localparam logic [15:0] CODE_ARM  = 16'h00E0;
  localparam logic [15:0] CODE_ID   = 16'h0090;
  localparam logic [15:0] CODE_CONF = 16'h0000;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WRST,
    CMD_ARM,
    CMD_ID,
    CMD_LOAD
  } cmd_cls_e;
endpackage

// File: rtl/boot_win_decode.sv
module boot_win_decode #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] LO_BASE = 'h0000,
  parameter logic [AW-1:0] LO_LAST = 'h01FF,
  parameter logic [AW-1:0] HI_BASE = 'h8000,
  parameter logic [AW-1:0] HI_LAST = 'h800F
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic in_lo, in_hi;
  assign in_lo = (addr_i >= LO_BASE) && (addr_i <= LO_LAST);
  assign in_hi = (addr_i >= HI_BASE) && (addr_i <= HI_LAST);
  assign hit_o = wr_en_i && (in_lo || in_hi);
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_cmd_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [DW-1:0] data_i,
  output cmd_cls_e      cls_o,
  output logic          armed_o
);
  logic armed_q;

  always_comb begin
    cls_o = CMD_NONE;
    if (hit_i) begin
      if (armed_q) begin
        // armed: any value disarms, only zero confirms
        if (data_i == CODE_CONF) cls_o = CMD_LOAD;
      end else begin
        unique case (data_i)
          CODE_WRST: cls_o = CMD_WRST;
          CODE_ARM:  cls_o = CMD_ARM;
          CODE_ID:   cls_o = CMD_ID;
          default:   cls_o = CMD_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (hit_i) armed_q <= (cls_o == CMD_ARM);
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/boot_sector_calc.sv
module boot_sector_calc #(
  parameter int unsigned BLK_W = 13,
  parameter logic [BLK_W-1:0] DENSITY_MASK = 'h1000,
  localparam int unsigned SEC_W = BLK_W + 8
) (
  input  logic [15:0]      blk_i,
  input  logic [15:0]      page_i,
  output logic [SEC_W-1:0] sector_o
);
  logic [BLK_W-1:0] blk_field;

  assign blk_field = {{(BLK_W-12){1'b0}}, blk_i[11:0]} | (blk_i[15] ? DENSITY_MASK : '0);
  // page index and sector-in-page fill disjoint bit fields: sums collapse to wiring
  assign sector_o = {blk_field, page_i[7:2], page_i[1:0]};
endmodule

// File: rtl/boot_ld_port.sv
module boot_ld_port #(
  parameter int unsigned SEC_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [SEC_W-1:0] sector_i,
  input  logic             ready_i,
  output logic             issue_o,
  output logic             valid_o,
  output logic [SEC_W-1:0] sector_o
);
  logic             valid_q;
  logic [SEC_W-1:0] sector_q;

  assign issue_o = req_i && (!valid_q || ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      sector_q <= '0;
    end else if (issue_o) begin
      valid_q  <= 1'b1;
      sector_q <= sector_i;
    end else if (ready_i) begin
      valid_q  <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign sector_o = sector_q;
endmodule

// File: rtl/boot_cmd_ctrl.sv
module boot_cmd_ctrl
  import boot_cmd_pkg::*;
#(
  parameter int unsigned BLK_W = 13,
  parameter logic [BLK_W-1:0] DENSITY_MASK = 'h1000,
  localparam int unsigned SEC_W = BLK_W + 8,
  localparam int unsigned DW = 16,
  localparam int unsigned ID_WORDS = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [15:0]            wr_addr_i,
  input  logic [15:0]            wr_data_i,
  input  logic [15:0]            blk_addr_i,
  input  logic                   pg_wr_i,
  input  logic [15:0]            pg_wdata_i,
  input  logic [15:0]            man_id_i,
  input  logic [15:0]            dev_id_i,
  input  logic [15:0]            wp_stat_i,
  input  logic                   ld_ready_i,
  output logic                   ld_valid_o,
  output logic [SEC_W-1:0]       ld_sector_o,
  output logic [15:0]            page_o,
  output logic                   armed_o,
  output logic                   warm_rst_o,
  output logic                   id_wr_o,
  output logic [ID_WORDS*DW-1:0] id_data_o
);
  logic             hit;
  cmd_cls_e         cls;
  logic [SEC_W-1:0] sector;
  logic             issue;
  logic [15:0]      page_q;
  logic             wrst_q, idwr_q;
  logic [ID_WORDS*DW-1:0] id_q;
  logic [ID_WORDS*DW-1:0] id_rec;

  boot_win_decode #(.AW(16)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (wr_addr_i),
    .hit_o   (hit)
  );

  boot_seq_fsm #(.DW(DW)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .data_i  (wr_data_i),
    .cls_o   (cls),
    .armed_o (armed_o)
  );

  boot_sector_calc #(.BLK_W(BLK_W), .DENSITY_MASK(DENSITY_MASK)) u_sec (
    .blk_i    (blk_addr_i),
    .page_i   (page_q),
    .sector_o (sector)
  );

  boot_ld_port #(.SEC_W(SEC_W)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (cls == CMD_LOAD),
    .sector_i (sector),
    .ready_i  (ld_ready_i),
    .issue_o  (issue),
    .valid_o  (ld_valid_o),
    .sector_o (ld_sector_o)
  );

  // identification record: one zero-extended low byte per word
  logic [7:0] id_src [ID_WORDS];
  assign id_src[0] = man_id_i[7:0];
  assign id_src[1] = dev_id_i[7:0];
  assign id_src[2] = wp_stat_i[7:0];

  for (genvar w = 0; w < ID_WORDS; w++) begin : g_id
    assign id_rec[w*DW +: DW] = {{(DW-8){1'b0}}, id_src[w]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      wrst_q <= 1'b0;
      idwr_q <= 1'b0;
      id_q   <= '0;
    end else begin
      wrst_q <= (cls == CMD_WRST);
      idwr_q <= (cls == CMD_ID);
      if (cls == CMD_ID) id_q <= id_rec;
      if (pg_wr_i)                 page_q <= pg_wdata_i;
      else if (issue)              page_q <= {8'h00, page_q[7:0] + 8'd4};
      else if (cls == CMD_WRST)    page_q <= '0;
    end
  end

  assign page_o     = page_q;
  assign warm_rst_o = wrst_q;
  assign id_wr_o    = idwr_q;
  assign id_data_o  = id_q;
endmodule

// File: rtl/boot_cmd_ctrl_chk.sv
module boot_cmd_ctrl_chk #(
  parameter int unsigned BLK_W = 13,
  localparam int unsigned SEC_W = BLK_W + 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [15:0]      wr_addr_i,
  input logic [15:0]      wr_data_i,
  input logic             pg_wr_i,
  input logic             ld_ready_i,
  input logic             ld_valid_o,
  input logic [SEC_W-1:0] ld_sector_o,
  input logic [15:0]      page_o,
  input logic             armed_o,
  input logic             warm_rst_o,
  input logic             id_wr_o
);
  logic win;
  assign win = wr_en_i && ((wr_addr_i <= 16'h01FF) ||
                           (wr_addr_i >= 16'h8000 && wr_addr_i <= 16'h800F));

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o && !ld_ready_i |=> ld_valid_o && $stable(ld_sector_o));

  p_disarm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && win |=> !armed_o);

  p_page_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && win && wr_data_i == 16'h0000 && (!ld_valid_o || ld_ready_i) && !pg_wr_i
    |=> ld_valid_o && page_o == {8'h00, $past(page_o[7:0]) + 8'd4});

  p_outside_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win |=> $stable(armed_o) && !warm_rst_o && !id_wr_o);

  p_unknown_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o && win && wr_data_i != 16'h00F0 && wr_data_i != 16'h00E0 && wr_data_i != 16'h0090
    |=> !armed_o && !warm_rst_o && !id_wr_o);

  p_busy_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && win && ld_valid_o && !ld_ready_i && !pg_wr_i |=> $stable(page_o));
endmodule

bind boot_cmd_ctrl boot_cmd_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .pg_wr_i     (pg_wr_i),
  .ld_ready_i  (ld_ready_i),
  .ld_valid_o  (ld_valid_o),
  .ld_sector_o (ld_sector_o),
  .page_o      (page_o),
  .armed_o     (armed_o),
  .warm_rst_o  (warm_rst_o),
  .id_wr_o     (id_wr_o)
);

// File: tb/tb_boot_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_boot_cmd_ctrl;
  localparam int unsigned BLK_W = 13;
  localparam logic [BLK_W-1:0] DMASK = 13'h1000;
  localparam int unsigned SEC_W = BLK_W + 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 0, pg_wr = 0, ready = 0;
  logic [15:0] waddr = 0, wdata = 0, blk = 0, pgd = 0;
  logic [15:0] man = 16'h12EC, dev = 16'h3458, wp = 16'h0A02;
  logic ld_valid, armed, wrst, idwr;
  logic [SEC_W-1:0] sector;
  logic [15:0] page;
  logic [47:0] iddata;

  int n_run = 0, n_fail = 0;

  // model state
  logic m_armed = 0, m_valid = 0, m_wrst = 0, m_idwr = 0;
  logic [SEC_W-1:0] m_sector = 0;
  logic [15:0] m_page = 0;
  logic [47:0] m_id = 0;

  always #2.5 clk = ~clk;

  boot_cmd_ctrl #(.BLK_W(BLK_W), .DENSITY_MASK(DMASK)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(waddr), .wr_data_i(wdata),
    .blk_addr_i(blk), .pg_wr_i(pg_wr), .pg_wdata_i(pgd), .man_id_i(man), .dev_id_i(dev),
    .wp_stat_i(wp), .ld_ready_i(ready), .ld_valid_o(ld_valid), .ld_sector_o(sector),
    .page_o(page), .armed_o(armed), .warm_rst_o(wrst), .id_wr_o(idwr), .id_data_o(iddata));

  function automatic logic in_win(logic [15:0] a);
    return (a <= 16'h01FF) || (a >= 16'h8000 && a <= 16'h800F);
  endfunction

  function automatic logic [SEC_W-1:0] exp_sector(logic [15:0] b, logic [15:0] p);
    int unsigned f;
    f = b[11:0];
    if (b[15]) f = f | DMASK;
    return SEC_W'(((f * 64 + p[7:2]) * 4) + p[1:0]);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic e, logic [15:0] a, logic [15:0] d, logic pw, logic [15:0] pv, logic r);
    logic hit, ld, iss, rs, idc;
    @(negedge clk);
    wr_en = e; waddr = a; wdata = d; pg_wr = pw; pgd = pv; ready = r;
    hit = e && in_win(a);
    ld  = hit && m_armed && d == 16'h0000;
    rs  = hit && !m_armed && d == 16'h00F0;
    idc = hit && !m_armed && d == 16'h0090;
    iss = ld && (!m_valid || r);
    if (iss) m_sector = exp_sector(blk, m_page);
    if (pw)        m_page = pv;
    else if (iss)  m_page = {8'h00, m_page[7:0] + 8'd4};
    else if (rs)   m_page = 16'h0;
    m_valid = iss ? 1'b1 : (r ? 1'b0 : m_valid);
    if (idc) m_id = {8'h00, wp[7:0], 8'h00, dev[7:0], 8'h00, man[7:0]};
    m_wrst = rs; m_idwr = idc;
    if (hit) m_armed = !m_armed && d == 16'h00E0;
    @(posedge clk); #1;
    chk("R4 armed", armed, m_armed);
    chk("R7 valid", ld_valid, m_valid);
    chk("R6 sector", sector, m_sector);
    chk("R5/R9 page", page, m_page);
    chk("R2 warm reset", wrst, m_wrst);
    chk("R3 id pulse", idwr, m_idwr);
    chk("R3 id data", iddata, m_id);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset armed", armed, 0);
    chk("R10 reset valid", ld_valid, 0);
    chk("R10 reset page", page, 0);
    chk("R10 reset pulses", {wrst, idwr}, 0);
    @(negedge clk); rst_ni = 1;

    // R5 R6: arm, confirm with density bit, wrap page
    blk = 16'h8123;
    step(1, 16'h0000, 16'h0, 1, 16'hABFC, 0);
    step(1, 16'h0010, 16'h00E0, 0, 0, 0);
    step(1, 16'h8005, 16'h0000, 0, 0, 0);
    chk("R6 density sector", sector, exp_sector(16'h8123, 16'hABFC));
    chk("R5 wrap page", page, 16'h0000);
    // R7: busy, confirm dropped
    step(1, 16'h0000, 16'h00E0, 0, 0, 0);
    step(1, 16'h0001, 16'h0000, 0, 0, 0);
    chk("R7 dropped page", page, 16'h0000);
    chk("R7 disarmed", armed, 0);
    // R7: accept and new confirm same cycle
    step(1, 16'h0000, 16'h00E0, 0, 0, 0);
    step(1, 16'h0001, 16'h0000, 0, 0, 1);
    chk("R7 back-to-back", {ld_valid, page}, {1'b1, 16'h0004});
    // R9: host write beats step
    step(1, 16'h0000, 16'h00E0, 0, 0, 1);
    step(1, 16'h0002, 16'h0000, 1, 16'h0077, 1);
    chk("R9 priority", page, 16'h0077);
    // R1: outside write while armed keeps arm
    step(1, 16'h0000, 16'h00E0, 0, 0, 1);
    step(1, 16'h4000, 16'h0000, 0, 0, 1);
    chk("R1 outside keeps arm", armed, 1);
    step(1, 16'h8010, 16'h00F0, 0, 0, 1);
    chk("R1 outside no reset", {armed, wrst}, 2'b10);
    // R4: F0 while armed consumes arm, no reset
    step(1, 16'h01FF, 16'h00F0, 0, 0, 1);
    chk("R4 armed F0 no reset", {armed, wrst}, 2'b00);
    // R8: unknown value idle
    step(1, 16'h0003, 16'h0091, 0, 0, 1);
    chk("R8 unknown ignored", {armed, wrst, idwr, ld_valid}, 4'b0000);
    // R2 R3
    step(1, 16'h0000, 16'h0090, 0, 0, 1);
    step(1, 16'h0000, 16'h00F0, 0, 0, 1);
    chk("R2 page clear", page, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a, d;
      int k;
      k = $urandom_range(0, 9);
      a = (k < 5) ? 16'($urandom_range(0, 16'h01FF)) :
          (k < 8) ? 16'(16'h8000 + $urandom_range(0, 15)) : 16'($urandom);
      k = $urandom_range(0, 9);
      d = (k < 3) ? 16'h00E0 : (k < 6) ? 16'h0000 : (k == 6) ? 16'h00F0 :
          (k == 7) ? 16'h0090 : 16'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        blk = 16'($urandom); man = 16'($urandom); dev = 16'($urandom); wp = 16'($urandom);
      end
      step($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 15) == 0,
           16'($urandom), $urandom_range(0, 2) != 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule